// File: doc/BRIEF.md
# Time Sync Health Supervisor

This block watches the health of a drive's time reference and steps the drive through a fixed ladder of degradation states. Each new synchronisation measurement arrives as a signed offset and an unsigned path delay, marked by a one-cycle strobe. Both values are compared against programmable limits. Beside these measurements, every clock channel reports a loss-of-signal flag and a PLL lock flag. The per-channel status is registered and kept apart, so a single-axis clock problem can be told from a global one.

The supervisor has four states: LOCKED (code 0), HOLDOVER (1), DERATED (2) and STOP (3). A measurement outside its limits, or a bad clock on any channel, moves a locked drive into holdover and marks time quality as degraded. If holdover runs out, the supervisor asks for derated operation. If derating also runs out, it asks for a controlled stop. A programmable number of consecutive good measurements with all clocks healthy brings the drive back to LOCKED from holdover or derate. STOP is left only through an explicit clear, and only after a programmable stable period. A dedicated time-source fault line to safety logic flags this fault class on its own. Offsets, limits and timeouts are inputs, so a register block elsewhere can own them.

Top module: `tsync_supervisor`

## Requirements
- R1: After reset the state output is LOCKED (code 0), and tq_degraded, derate_req, stop_req, alarm, ts_fault, chan_fault and global_fault are all 0.
- R2: A strobed measurement is in limit when the absolute offset is at most lim_offset and the delay is at most lim_delay, both bounds inclusive. An out-of-limit measurement seen in LOCKED moves the state to HOLDOVER two cycles after the strobe.
- R3: When any channel shows clk_los high or pll_lock low, alarm rises one cycle later. From LOCKED, the state leaves LOCKED one cycle after alarm rises.
- R4: tq_degraded is high in every state other than LOCKED. ts_fault is high whenever tq_degraded or alarm is high.
- R5: With hold_cycles = H > 0, an unresolved HOLDOVER lasts exactly H cycles and then moves to DERATED, where derate_req is high.
- R6: With derate_cycles = D > 0, an unresolved DERATED lasts exactly D cycles and then moves to STOP, where stop_req is high. DERATED never returns to HOLDOVER.
- R7: A zero timeout skips its state. If hold_cycles is 0, a fault in LOCKED goes straight to DERATED. If both timeouts are 0, it goes straight to STOP.
- R8: HOLDOVER or DERATED returns to LOCKED after good_needed consecutive in-limit measurements taken while every channel is healthy. A good_needed of 0 acts as 1. An out-of-limit measurement or a clock fault restarts the count.
- R9: STOP is held while clear_stop is low. A clear_stop pulse returns to LOCKED only if no channel is faulted and at least stable_cycles fault-free cycles have passed in STOP. Otherwise the pulse is ignored, and a pulse in LOCKED has no effect.
- R10: chan_fault[i] shows channel i's clock fault one cycle after its inputs. global_fault is high when all channels are faulted, or when the latest measurement was out of limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe for a new measurement |
| meas_offset | input | OFS_W | Signed time offset of the measurement |
| meas_delay | input | DLY_W | Unsigned path delay of the measurement |
| lim_offset | input | OFS_W | Maximum allowed absolute offset |
| lim_delay | input | DLY_W | Maximum allowed path delay |
| clk_los | input | NCH | Per-channel loss-of-signal, 1 = lost |
| pll_lock | input | NCH | Per-channel PLL lock, 1 = locked |
| hold_cycles | input | CNT_W | Holdover window in cycles |
| derate_cycles | input | CNT_W | Derate window in cycles |
| good_needed | input | GOOD_W | Consecutive good measurements needed to relock |
| stable_cycles | input | CNT_W | Fault-free cycles in STOP before a clear is accepted |
| clear_stop | input | 1 | Request to leave STOP |
| state | output | 2 | Current state code |
| tq_degraded | output | 1 | Time quality degraded |
| alarm | output | 1 | Some clock channel faulted |
| derate_req | output | 1 | Derated operation requested |
| stop_req | output | 1 | Controlled stop requested |
| ts_fault | output | 1 | Time-source fault line to safety logic |
| chan_fault | output | NCH | Registered per-channel clock fault |
| global_fault | output | 1 | All channels faulted, or latest measurement out of limit |

## Verification
The properties assume that the strobe is a single-cycle pulse and that the limit and timeout inputs stay constant while a fault sequence is in progress. Without that, the window lengths and the two-cycle delay from measurement to state change are not defined. The stimulus sets limits and timeouts only while the block is LOCKED and idle, and drives each strobe for exactly one cycle. It also leaves gaps wide enough that a holdover timeout never lands in the same cycle as a recovery, except where the test means it to.

// File: rtl/tsync_pkg.sv
// Package: shared state encoding for the time sync health supervisor.
// Assumes the state codes are decoded by neighbours, so values are fixed.
package tsync_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_HOLD   = 2'd1,
        ST_DERATE = 2'd2,
        ST_STOP   = 2'd3
    } tsync_state_e;

endpackage

// File: rtl/tsync_meas_check.sv
// Module: tsync_meas_check
// Registers a limit verdict for each strobed measurement. The absolute offset
// is formed one bit wider, so the most negative value does not overflow.
// It assumes meas_valid is a one-cycle strobe, and it keeps a latched copy of
// the most recent verdict.
module tsync_meas_check #(
    parameter int OFS_W = 32,
    parameter int DLY_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    meas_valid,
    input  logic signed [OFS_W-1:0] meas_offset,
    input  logic        [DLY_W-1:0] meas_delay,
    input  logic        [OFS_W-1:0] lim_offset,
    input  logic        [DLY_W-1:0] lim_delay,
    output logic                    chk_valid,
    output logic                    chk_ok,
    output logic                    meas_bad
);

    localparam int MAG_W = OFS_W + 1;

    logic [MAG_W-1:0] ofs_mag;
    logic             in_limit;

    // Absolute value of the offset and the combined limit verdict.
    always_comb begin
        if (meas_offset[OFS_W-1]) begin
            ofs_mag = {1'b0, ~meas_offset} + {{OFS_W{1'b0}}, 1'b1};
        end else begin
            ofs_mag = {1'b0, meas_offset};
        end
        in_limit = (ofs_mag <= {1'b0, lim_offset}) && (meas_delay <= lim_delay);
    end

    // Register the verdict and the latched last-measurement status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            chk_ok    <= 1'b0;
            meas_bad  <= 1'b0;
        end else begin
            chk_valid <= meas_valid;
            chk_ok    <= meas_valid & in_limit;
            if (meas_valid) begin
                meas_bad <= ~in_limit;
            end
        end
    end

endmodule

// File: rtl/tsync_chan_mon.sv
// Module: tsync_chan_mon
// Holds one registered fault flag per clock channel (signal lost or PLL
// unlocked) and reduces the flags to "any" and "all" summaries. The inputs
// are assumed to be already synchronised to clk.
module tsync_chan_mon #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] clk_los,
    input  logic [NCH-1:0] pll_lock,
    output logic [NCH-1:0] chan_bad,
    output logic           any_bad,
    output logic           all_bad
);

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        // Per-channel fault register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_bad[i] <= 1'b0;
            end else begin
                chan_bad[i] <= clk_los[i] | ~pll_lock[i];
            end
        end
    end

    // Summaries that separate a single-axis fault from a global one.
    always_comb begin
        any_bad = |chan_bad;
        all_bad = &chan_bad;
    end

endmodule

// File: rtl/tsync_fsm.sv
// Module: tsync_fsm
// Degradation state machine with three counters. The window timer restarts on
// every state change. The good counter counts consecutive good measurements.
// The stable counter counts fault-free cycles spent in STOP. It assumes the
// limits and timeouts stay constant while a fault sequence runs.
module tsync_fsm
    import tsync_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int GOOD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              chk_ok,
    input  logic              any_bad,
    input  logic [CNT_W-1:0]  hold_cycles,
    input  logic [CNT_W-1:0]  derate_cycles,
    input  logic [GOOD_W-1:0] good_needed,
    input  logic [CNT_W-1:0]  stable_cycles,
    input  logic              clear_stop,
    output tsync_state_e      state
);

    localparam int TW = CNT_W + 1;
    localparam int GW = GOOD_W + 1;

    tsync_state_e      state_nxt;
    tsync_state_e      after_fault;
    tsync_state_e      after_hold;
    logic [CNT_W-1:0]  timer;
    logic [GOOD_W-1:0] good_cnt;
    logic [CNT_W-1:0]  stable_cnt;
    logic              sync_loss;
    logic              fault;
    logic              good_meas;
    logic [GW-1:0]     need;
    logic              recovered;
    logic [TW-1:0]     timer_inc;
    logic              hold_expired;
    logic              derate_expired;
    logic              stable_ok;

    // Classify this cycle's events and evaluate every window.
    always_comb begin
        sync_loss      = chk_valid & ~chk_ok;
        fault          = sync_loss | any_bad;
        good_meas      = chk_valid & chk_ok & ~any_bad;
        need           = (good_needed == '0) ? {{GOOD_W{1'b0}}, 1'b1}
                                              : {1'b0, good_needed};
        recovered      = good_meas &&
                         (({1'b0, good_cnt} + {{GOOD_W{1'b0}}, 1'b1}) >= need);
        timer_inc      = {1'b0, timer} + {{CNT_W{1'b0}}, 1'b1};
        hold_expired   = timer_inc >= {1'b0, hold_cycles};
        derate_expired = timer_inc >= {1'b0, derate_cycles};
        stable_ok      = (stable_cnt >= stable_cycles) && !any_bad;
        after_hold     = (derate_cycles == '0) ? ST_STOP : ST_DERATE;
        after_fault    = (hold_cycles == '0) ? after_hold : ST_HOLD;
    end

    // Next-state selection. Recovery takes priority over a window expiry.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_LOCKED: begin
                if (fault) state_nxt = after_fault;
            end
            ST_HOLD: begin
                if (recovered)         state_nxt = ST_LOCKED;
                else if (hold_expired) state_nxt = after_hold;
            end
            ST_DERATE: begin
                if (recovered)           state_nxt = ST_LOCKED;
                else if (derate_expired) state_nxt = ST_STOP;
            end
            ST_STOP: begin
                if (clear_stop && stable_ok) state_nxt = ST_LOCKED;
            end
            default: state_nxt = ST_STOP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nxt;
    end

    // Window timer: restarts on each state change and saturates at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || (state_nxt != state)) begin
            timer <= '0;
        end else if (timer != {CNT_W{1'b1}}) begin
            timer <= timer + 1'b1;
        end
    end

    // Consecutive good-measurement counter, active only while recovering.
    always_ff @(posedge clk) begin
        if (!rst_n || fault || (state == ST_LOCKED) || (state == ST_STOP)) begin
            good_cnt <= '0;
        end else if (good_meas && (good_cnt != {GOOD_W{1'b1}})) begin
            good_cnt <= good_cnt + 1'b1;
        end
    end

    // Fault-free cycle counter used to qualify a clear while in STOP.
    always_ff @(posedge clk) begin
        if (!rst_n || fault || (state != ST_STOP)) begin
            stable_cnt <= '0;
        end else if (stable_cnt != {CNT_W{1'b1}}) begin
            stable_cnt <= stable_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tsync_supervisor.sv
// Module: tsync_supervisor (top)
// Joins the measurement limit check, the per-channel clock monitor and the
// degradation state machine, and decodes the state into request lines. It
// assumes all inputs are synchronous to clk.
module tsync_supervisor
    import tsync_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int OFS_W  = 32,
    parameter int DLY_W  = 32,
    parameter int CNT_W  = 24,
    parameter int GOOD_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    meas_valid,
    input  logic signed [OFS_W-1:0] meas_offset,
    input  logic        [DLY_W-1:0] meas_delay,
    input  logic        [OFS_W-1:0] lim_offset,
    input  logic        [DLY_W-1:0] lim_delay,
    input  logic        [NCH-1:0]   clk_los,
    input  logic        [NCH-1:0]   pll_lock,
    input  logic        [CNT_W-1:0] hold_cycles,
    input  logic        [CNT_W-1:0] derate_cycles,
    input  logic       [GOOD_W-1:0] good_needed,
    input  logic        [CNT_W-1:0] stable_cycles,
    input  logic                    clear_stop,
    output logic        [1:0]       state,
    output logic                    tq_degraded,
    output logic                    alarm,
    output logic                    derate_req,
    output logic                    stop_req,
    output logic                    ts_fault,
    output logic        [NCH-1:0]   chan_fault,
    output logic                    global_fault
);

    logic         chk_valid;
    logic         chk_ok;
    logic         meas_bad;
    logic         any_bad;
    logic         all_bad;
    tsync_state_e st;

    tsync_meas_check #(.OFS_W(OFS_W), .DLY_W(DLY_W)) u_meas (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .meas_offset(meas_offset),
        .meas_delay (meas_delay),
        .lim_offset (lim_offset),
        .lim_delay  (lim_delay),
        .chk_valid  (chk_valid),
        .chk_ok     (chk_ok),
        .meas_bad   (meas_bad)
    );

    tsync_chan_mon #(.NCH(NCH)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_los (clk_los),
        .pll_lock(pll_lock),
        .chan_bad(chan_fault),
        .any_bad (any_bad),
        .all_bad (all_bad)
    );

    tsync_fsm #(.CNT_W(CNT_W), .GOOD_W(GOOD_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .chk_valid    (chk_valid),
        .chk_ok       (chk_ok),
        .any_bad      (any_bad),
        .hold_cycles  (hold_cycles),
        .derate_cycles(derate_cycles),
        .good_needed  (good_needed),
        .stable_cycles(stable_cycles),
        .clear_stop   (clear_stop),
        .state        (st)
    );

    // Decode the state and the fault summaries into the output lines.
    always_comb begin
        state        = st;
        tq_degraded  = (st != ST_LOCKED);
        derate_req   = (st == ST_DERATE);
        stop_req     = (st == ST_STOP);
        alarm        = any_bad;
        ts_fault     = tq_degraded | any_bad;
        global_fault = all_bad | meas_bad;
    end

endmodule

// File: rtl/tsync_supervisor_chk.sv
// Module: tsync_supervisor_chk
// Temporal properties of the supervisor, attached to the top through bind.
// Assumes single-cycle strobes and timeouts held constant during a sequence.
module tsync_supervisor_chk #(
    parameter int NCH   = 4,
    parameter int DLY_W = 32,
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_valid,
    input logic [DLY_W-1:0] meas_delay,
    input logic [DLY_W-1:0] lim_delay,
    input logic [NCH-1:0]   clk_los,
    input logic [NCH-1:0]   pll_lock,
    input logic [CNT_W-1:0] derate_cycles,
    input logic             clear_stop,
    input logic [1:0]       state,
    input logic             alarm
);

    // R2: an over-limit delay in LOCKED leaves LOCKED two cycles later.
    assert_delay_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && meas_valid && meas_delay > lim_delay) |-> ##2 (state != 2'd0));

    // R3: a channel clock fault raises alarm in the next cycle.
    assert_clock_alarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clk_los | ~pll_lock)) |=> alarm);

    // R5: holdover never skips derate when the derate window is non-zero.
    assert_hold_no_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && derate_cycles != '0) |=> (state != 2'd3));

    // R6: derate never falls back into holdover.
    assert_derate_no_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2) |=> (state != 2'd1));

    // R9: STOP is held while no clear is requested.
    assert_stop_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3 && !clear_stop) |=> (state == 2'd3));

endmodule

bind tsync_supervisor tsync_supervisor_chk #(
    .NCH  (NCH),
    .DLY_W(DLY_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .meas_valid   (meas_valid),
    .meas_delay   (meas_delay),
    .lim_delay    (lim_delay),
    .clk_los      (clk_los),
    .pll_lock     (pll_lock),
    .derate_cycles(derate_cycles),
    .clear_stop   (clear_stop),
    .state        (state),
    .alarm        (alarm)
);

// File: tb/tb_tsync_supervisor.sv
// Bench: scoreboard for tsync_supervisor. Driver tasks move the inputs on the
// falling edge and push expected output items into a queue. A monitor process
// pops each item shortly after the falling edge on which it falls due and
// compares it with the design's outputs.
module tb_tsync_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int OFS_W = 32;
    localparam int DLY_W = 32;
    localparam int CNT_W = 24;
    localparam int GOOD_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic meas_valid = 1'b0;
    logic signed [OFS_W-1:0] meas_offset = '0;
    logic [DLY_W-1:0] meas_delay = '0;
    logic [OFS_W-1:0] lim_offset = 32'd100;
    logic [DLY_W-1:0] lim_delay = 32'd1000;
    logic [NCH-1:0] clk_los = '0;
    logic [NCH-1:0] pll_lock = '1;
    logic [CNT_W-1:0] hold_cycles = 24'd5;
    logic [CNT_W-1:0] derate_cycles = 24'd4;
    logic [GOOD_W-1:0] good_needed = 8'd3;
    logic [CNT_W-1:0] stable_cycles = 24'd6;
    logic clear_stop = 1'b0;
    logic [1:0] state;
    logic tq_degraded, alarm, derate_req, stop_req, ts_fault, global_fault;
    logic [NCH-1:0] chan_fault;

    tsync_supervisor #(.NCH(NCH), .OFS_W(OFS_W), .DLY_W(DLY_W),
                       .CNT_W(CNT_W), .GOOD_W(GOOD_W)) dut (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
        .meas_offset(meas_offset), .meas_delay(meas_delay),
        .lim_offset(lim_offset), .lim_delay(lim_delay),
        .clk_los(clk_los), .pll_lock(pll_lock),
        .hold_cycles(hold_cycles), .derate_cycles(derate_cycles),
        .good_needed(good_needed), .stable_cycles(stable_cycles),
        .clear_stop(clear_stop), .state(state), .tq_degraded(tq_degraded),
        .alarm(alarm), .derate_req(derate_req), .stop_req(stop_req),
        .ts_fault(ts_fault), .chan_fault(chan_fault), .global_fault(global_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          due;
        logic [11:0] outs;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   ncyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic mb = 1'b0;
    bit   done = 1'b0;

    // Cycle counter used to time the scoreboard items.
    always @(posedge clk) ncyc <= ncyc + 1;

    // Pack outputs as {state, tqd, alarm, derate, stop, tsf, chan_fault, glb}.
    function automatic logic [11:0] pack_outs(logic [1:0] st, logic tqd, logic alm,
                                              logic der, logic stp, logic tsf,
                                              logic [NCH-1:0] chf, logic glb);
        return {st, tqd, alm, der, stp, tsf, chf, glb};
    endfunction

    // Monitor: compares every item that falls due with the live outputs.
    always @(negedge clk) begin
        #1;
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].due <= ncyc) begin
                logic [11:0] act;
                act = pack_outs(state, tq_degraded, alarm, derate_req, stop_req,
                                ts_fault, chan_fault, global_fault);
                checks++;
                if (act !== exp_q[i].outs) begin
                    errors++;
                    $display("FAIL %s actual=%b expected=%b", exp_q[i].tag, act, exp_q[i].outs);
                end
                exp_q.delete(i);
            end
        end
    end

    // Driver-side expectation: full outputs built from the requirement rules.
    task automatic expect_st(logic [1:0] st, string tag);
        exp_t e;
        logic [NCH-1:0] bad;
        logic alm;
        logic tqd;
        bad = clk_los | ~pll_lock;
        alm = |bad;
        tqd = (st != 2'd0);
        e.due  = ncyc;
        e.outs = pack_outs(st, tqd, alm, st == 2'd2, st == 2'd3, tqd | alm,
                           bad, (&bad) | mb);
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic meas(int off, int dly);
        int mag;
        meas_valid  = 1'b1;
        meas_offset = off;
        meas_delay  = dly;
        tick(1);
        meas_valid = 1'b0;
        mag = (off < 0) ? -off : off;
        mb = !((mag <= int'(lim_offset)) && (dly <= int'(lim_delay)));
    endtask

    task automatic pulse_clear();
        clear_stop = 1'b1;
        tick(1);
        clear_stop = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_st(2'd0, "R1 reset state");

        // R2: inclusive bounds keep LOCKED
        meas(100, 1000); tick(1);
        expect_st(2'd0, "R2 offset and delay at limit");
        meas(-100, 0); tick(1);
        expect_st(2'd0, "R2 negative offset at limit");

        // R2/R5/R6: fault, holdover window, derate window
        meas(-101, 10); tick(1);
        expect_st(2'd1, "R2 R4 out-of-limit offset to holdover");
        tick(4);
        expect_st(2'd1, "R5 last holdover cycle");
        tick(1);
        expect_st(2'd2, "R5 holdover expiry to derate");
        tick(3);
        expect_st(2'd2, "R6 last derate cycle");
        tick(1);
        expect_st(2'd3, "R6 derate expiry to stop");

        // R9: early clear ignored, clear during clock fault ignored
        pulse_clear();
        expect_st(2'd3, "R9 clear before stable period");
        tick(1);
        expect_st(2'd3, "R9 stop held");
        pll_lock[0] = 1'b0;
        tick(10);
        pulse_clear();
        expect_st(2'd3, "R9 clear while channel faulted");
        pll_lock[0] = 1'b1;
        tick(3);
        pulse_clear();
        expect_st(2'd3, "R9 clear before stable after fault");
        tick(8);
        pulse_clear();
        expect_st(2'd0, "R9 clear after stable period");

        // R8: consecutive count restarted by a bad measurement
        hold_cycles = 24'd20;
        tick(1);
        meas(5, 1001); tick(1);
        expect_st(2'd1, "R2 over-limit delay to holdover");
        meas(0, 0); meas(0, 0); meas(200, 0); meas(0, 0); meas(0, 0);
        tick(1);
        expect_st(2'd1, "R8 count restarted by bad measurement");
        meas(0, 0); tick(1);
        expect_st(2'd0, "R8 relock after N good");

        // R3/R10: single channel lock loss
        pll_lock[2] = 1'b0;
        tick(1);
        expect_st(2'd0, "R3 R10 alarm one cycle after lock loss");
        tick(1);
        expect_st(2'd1, "R3 holdover after alarm");
        pll_lock[2] = 1'b1;
        tick(1);
        meas(1, 1); meas(1, 1); meas(1, 1); tick(1);
        expect_st(2'd0, "R8 relock after clock restored");

        // R10: global fault when all channels lose signal
        clk_los = '1;
        tick(1);
        expect_st(2'd0, "R10 all channels faulted");
        tick(1);
        expect_st(2'd1, "R10 global clock fault holdover");
        clk_los = '0;
        tick(1);
        meas(2, 2); meas(2, 2); meas(2, 2); tick(1);
        expect_st(2'd0, "R8 relock after global fault");

        // R7: zero holdover goes to derate, recovery from derate
        hold_cycles = 24'd0;
        derate_cycles = 24'd30;
        tick(1);
        meas(1000, 0); tick(1);
        expect_st(2'd2, "R7 zero holdover straight to derate");
        meas(0, 0); meas(0, 0); meas(0, 0); tick(1);
        expect_st(2'd0, "R8 relock from derate");

        // R7: both zero go straight to stop
        derate_cycles = 24'd0;
        tick(1);
        meas(0, 5000); tick(1);
        expect_st(2'd3, "R7 zero windows straight to stop");
        tick(8);
        pulse_clear();
        expect_st(2'd0, "R9 clear from stop after zero windows");

        // R8: good_needed of zero acts as one
        hold_cycles = 24'd20;
        derate_cycles = 24'd20;
        good_needed = 8'd0;
        tick(1);
        meas(-500, 0); tick(1);
        expect_st(2'd1, "R2 fault before single-sample relock");
        meas(0, 0); tick(1);
        expect_st(2'd0, "R8 N of zero acts as one");

        // R9: clear in LOCKED has no effect
        pulse_clear();
        tick(1);
        expect_st(2'd0, "R9 clear in locked ignored");

        tick(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule